// File: doc/BRIEF.md
# Speculative Separable Switch Allocator

This block decides, once per cycle, which input virtual channels of a router may cross the switch. Each input VC presents a request valid bit, the output port it wants and a flag saying whether the request is speculative. A speculative request belongs to a head flit whose VC allocation is being resolved in the same cycle. The surrounding logic supplies that flag together with a per-VC VC-allocation-success bit. Requests from body and tail flits come in as non-speculative, because those flits already hold the VC of their head flit.

Two identical two-stage separable allocators run side by side. One sees only the non-speculative requests and the other only the speculative ones. In each allocator, a round-robin arbiter per input first chooses one VC among that input's requesters. A round-robin arbiter per output then chooses one input among the stage-one winners aiming at that output. The two results are merged. A non-speculative grant always takes an output ahead of a speculative one, and an input that wins non-speculatively loses any speculative grant it also won. A surviving speculative grant whose VC allocation failed is flagged as wasted, sends nothing and is retried.

The grant outputs are combinational from the current requests and the arbiters' pointer state. A pointer moves past its winner only when that grant is actually used, so a dropped or wasted grant leaves every pointer where it was.

Top module: `spec_sw_alloc`

## Requirements
- R1: In each cycle and for each class (speculative or not), every input selects at most one of its valid VCs of that class. The VC of the grant finally given to input i is reported on `sw_vc[i*VW +: VW]`.
- R2: Row i of `sw_gnt` (bits `[i*P +: P]`, where bit o means output o) has at most one bit set in every cycle.
- R3: For every output o, at most one input has bit o set in its `sw_gnt` row in every cycle.
- R4: When row i is non-zero, the VC named by `sw_vc` for input i has a valid request, and the single set bit is the output held in that VC's port field `req_port[(i*V+v)*PW +: PW]`.
- R5: When a non-speculative request and a speculative request both win the same output, the non-speculative one is granted and the speculative one receives nothing.
- R6: An input that wins a non-speculative grant receives no speculative grant in the same cycle. Its speculative winner is dropped and the output that winner targeted stays free unless another input is granted it.
- R7: A surviving speculative grant whose VC-allocation-success bit `va_ok[i*V+v]` is 0 raises `sw_waste[i]`, leaves row i zero and reports that VC on `sw_vc`. A granted speculative VC always has `va_ok` set.
- R8: A dropped or wasted grant leaves all arbiter pointers unchanged, so identical requests in the next cycle select the same winner.
- R9: Output arbitration is round-robin. Under constant requests from all P inputs to one output, each input is granted exactly once in any P consecutive cycles.
- R10: Input arbitration is round-robin. An input whose two VCs keep requesting different outputs alternates between them on consecutive cycles.
- R11: After reset all pointers favour index 0. With no requests there are no grants and no waste flags.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_vld | input | P*V | Request valid, bit i*V+v for VC v of input i |
| req_port | input | P*V*PW | Wanted output port per input VC |
| req_spec | input | P*V | 1 = speculative request (head flit awaiting VC allocation) |
| va_ok | input | P*V | VC allocation succeeded for this input VC this cycle |
| sw_gnt | output | P*P | Per-input one-hot output grant rows |
| sw_vc | output | P*VW | VC index behind each input's grant or waste flag |
| sw_waste | output | P | Speculative grant won but VC allocation failed |

## Verification
The bench builds the allocator with 5 ports and 2 VCs per port. This is the smallest shape in which every input owns two competing VCs and five inputs contend for one output, so input-side alternation and a full five-cycle output rotation can both be observed. With 10 request slots and a 3-bit port field, a long random sweep over valid bits, ports, speculative flags and VC-allocation results exercises most merge situations. Directed sequences started from reset then pin down exact winners: precedence, the double-booking drop, and the unchanged pointer after a wasted grant.

// File: rtl/ssa_pkg.sv
package ssa_pkg;
  // width of an index into n items, at least one bit
  function automatic int idx_w(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/ssa_rr_arb.sv
module ssa_rr_arb #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] req,
  input  logic         adv,
  output logic [N-1:0] gnt
);
  localparam int IW = ssa_pkg::idx_w(N);

  logic [IW-1:0] ptr_q;
  logic [IW-1:0] ptr_d;
  logic          found;

  // pick: first requester at or after the pointer, wrapping
  always_comb begin
    gnt   = '0;
    found = 1'b0;
    for (int k = 0; k < N; k++) begin
      int s;
      s = int'(ptr_q) + k;
      if (s >= N) s = s - N;
      if (!found && req[s]) begin
        gnt[s] = 1'b1;
        found  = 1'b1;
      end
    end
  end

  // next pointer: one past the winner, only when the grant is used
  always_comb begin
    ptr_d = ptr_q;
    for (int k = 0; k < N; k++) begin
      if (gnt[k]) ptr_d = (k == N-1) ? '0 : IW'(k + 1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   ptr_q <= '0;
    else if (adv) ptr_q <= ptr_d;
  end

  a_r1_arb_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt));
  a_r1_arb_subset: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt & ~req) == '0);
  a_r1_arb_work: assert property (@(posedge clk) disable iff (!rst_n)
    (req != '0) |-> (gnt != '0));
endmodule

// File: rtl/ssa_sep_stage.sv
module ssa_sep_stage #(
  parameter int P  = 5,
  parameter int V  = 2,
  parameter int PW = ssa_pkg::idx_w(P),
  parameter int VW = ssa_pkg::idx_w(V)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [P*V-1:0]  vld,
  input  logic [P*V*PW-1:0] port,
  input  logic [P-1:0]    use_in,
  input  logic [P-1:0]    use_out,
  output logic [P*P-1:0]  gnt,     // bit i*P+o : input i won output o
  output logic [P*VW-1:0] win_vc
);
  logic [P*V-1:0]  s1_gnt;
  logic [P*P-1:0]  s2_req;   // bit o*P+i
  logic [P*P-1:0]  s2_gnt;   // bit o*P+i
  logic [P-1:0]    has_win;
  logic [PW-1:0]   win_port [P];
  logic [VW-1:0]   win_idx  [P];

  // stage one: a V-way arbiter per input
  for (genvar gi = 0; gi < P; gi++) begin : g_in
    ssa_rr_arb #(.N(V)) i_in_arb (
      .clk   (clk),
      .rst_n (rst_n),
      .req   (vld[gi*V +: V]),
      .adv   (use_in[gi]),
      .gnt   (s1_gnt[gi*V +: V])
    );
  end

  always_comb begin
    for (int i = 0; i < P; i++) begin
      win_idx[i]  = '0;
      win_port[i] = '0;
      has_win[i]  = |s1_gnt[i*V +: V];
      for (int v = 0; v < V; v++) begin
        if (s1_gnt[i*V+v]) begin
          win_idx[i]  = VW'(v);
          win_port[i] = port[(i*V+v)*PW +: PW];
        end
      end
      win_vc[i*VW +: VW] = win_idx[i];
    end
  end

  always_comb begin
    for (int o = 0; o < P; o++)
      for (int i = 0; i < P; i++)
        s2_req[o*P+i] = has_win[i] && (int'(win_port[i]) == o);
  end

  // stage two: a P-way arbiter per output
  for (genvar go = 0; go < P; go++) begin : g_out
    ssa_rr_arb #(.N(P)) i_out_arb (
      .clk   (clk),
      .rst_n (rst_n),
      .req   (s2_req[go*P +: P]),
      .adv   (use_out[go]),
      .gnt   (s2_gnt[go*P +: P])
    );
  end

  always_comb begin
    for (int i = 0; i < P; i++)
      for (int o = 0; o < P; o++)
        gnt[i*P+o] = s2_gnt[o*P+i];
  end

  for (genvar gi = 0; gi < P; gi++) begin : g_chk
    a_r2_stage_row: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(gnt[gi*P +: P]));
  end
endmodule

// File: rtl/spec_sw_alloc.sv
module spec_sw_alloc #(
  parameter int P  = 5,
  parameter int V  = 2,
  parameter int PW = ssa_pkg::idx_w(P),
  parameter int VW = ssa_pkg::idx_w(V)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [P*V-1:0]    req_vld,
  input  logic [P*V*PW-1:0] req_port,
  input  logic [P*V-1:0]    req_spec,
  input  logic [P*V-1:0]    va_ok,
  output logic [P*P-1:0]    sw_gnt,
  output logic [P*VW-1:0]   sw_vc,
  output logic [P-1:0]      sw_waste
);
  localparam int NR = P*V;

  logic [NR-1:0]   ns_vld, sp_vld;
  logic [P*P-1:0]  ns_gnt, sp_gnt, sp_keep;
  logic [P*VW-1:0] ns_vc, sp_vc;
  logic [P-1:0]    ns_in_any, ns_out_any;
  logic [P-1:0]    sp_in_keep, va_hit;
  logic [P-1:0]    sp_use_in, sp_use_out;
  logic [P*P-1:0]  col_view;   // bit o*P+i

  assign ns_vld = req_vld & ~req_spec;
  assign sp_vld = req_vld &  req_spec;

  ssa_sep_stage #(.P(P), .V(V), .PW(PW), .VW(VW)) i_ns_alloc (
    .clk     (clk),
    .rst_n   (rst_n),
    .vld     (ns_vld),
    .port    (req_port),
    .use_in  (ns_in_any),
    .use_out (ns_out_any),
    .gnt     (ns_gnt),
    .win_vc  (ns_vc)
  );

  ssa_sep_stage #(.P(P), .V(V), .PW(PW), .VW(VW)) i_sp_alloc (
    .clk     (clk),
    .rst_n   (rst_n),
    .vld     (sp_vld),
    .port    (req_port),
    .use_in  (sp_use_in),
    .use_out (sp_use_out),
    .gnt     (sp_gnt),
    .win_vc  (sp_vc)
  );

  // merge: non-speculative first, per output and per input
  always_comb begin
    ns_out_any = '0;
    for (int i = 0; i < P; i++) begin
      ns_in_any[i] = |ns_gnt[i*P +: P];
      for (int o = 0; o < P; o++)
        ns_out_any[o] = ns_out_any[o] | ns_gnt[i*P+o];
    end
    sp_use_out = '0;
    for (int i = 0; i < P; i++) begin
      for (int o = 0; o < P; o++)
        sp_keep[i*P+o] = sp_gnt[i*P+o] & ~ns_out_any[o] & ~ns_in_any[i];
      sp_in_keep[i] = |sp_keep[i*P +: P];
      va_hit[i]     = va_ok[i*V + int'(sp_vc[i*VW +: VW])];
      sp_use_in[i]  = sp_in_keep[i] & va_hit[i];
      for (int o = 0; o < P; o++)
        sp_use_out[o] = sp_use_out[o] | (sp_keep[i*P+o] & va_hit[i]);
      sw_gnt[i*P +: P]   = ns_gnt[i*P +: P] | (sp_keep[i*P +: P] & {P{va_hit[i]}});
      sw_vc[i*VW +: VW]  = ns_in_any[i] ? ns_vc[i*VW +: VW] : sp_vc[i*VW +: VW];
      sw_waste[i]        = sp_in_keep[i] & ~va_hit[i];
    end
  end

  always_comb begin
    for (int o = 0; o < P; o++)
      for (int i = 0; i < P; i++)
        col_view[o*P+i] = sw_gnt[i*P+o];
  end

  for (genvar gi = 0; gi < P; gi++) begin : g_chk_in
    a_r2_row_onehot: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(sw_gnt[gi*P +: P]));
    a_r4_gnt_match: assert property (@(posedge clk) disable iff (!rst_n)
      (sw_gnt[gi*P +: P] != '0) |->
        (req_vld[gi*V + int'(sw_vc[gi*VW +: VW])] &&
         sw_gnt[gi*P + int'(req_port[(gi*V + int'(sw_vc[gi*VW +: VW]))*PW +: PW])]));
    a_r7_spec_needs_va: assert property (@(posedge clk) disable iff (!rst_n)
      ((sw_gnt[gi*P +: P] != '0) && req_spec[gi*V + int'(sw_vc[gi*VW +: VW])]) |->
        va_ok[gi*V + int'(sw_vc[gi*VW +: VW])]);
    a_r7_waste_idle: assert property (@(posedge clk) disable iff (!rst_n)
      sw_waste[gi] |-> (sw_gnt[gi*P +: P] == '0));
  end

  for (genvar go = 0; go < P; go++) begin : g_chk_out
    a_r3_col_onehot: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(col_view[go*P +: P]));
  end
endmodule

// File: tb/test_spec_sw_alloc.sv
module test_spec_sw_alloc;
  localparam int P     = 5;
  localparam int V     = 2;
  localparam int PW    = 3;
  localparam int VW    = 1;
  localparam int CLK_P = 10;

  logic clk = 1'b0;
  logic rst_n;
  logic [P*V-1:0]    req_vld, req_spec, va_ok;
  logic [P*V*PW-1:0] req_port;
  logic [P*P-1:0]    sw_gnt;
  logic [P*VW-1:0]   sw_vc;
  logic [P-1:0]      sw_waste;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  spec_sw_alloc #(.P(P), .V(V)) i_spec_sw_alloc (
    .clk(clk), .rst_n(rst_n), .req_vld(req_vld), .req_port(req_port),
    .req_spec(req_spec), .va_ok(va_ok), .sw_gnt(sw_gnt), .sw_vc(sw_vc),
    .sw_waste(sw_waste)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic clr();
    req_vld = '0; req_spec = '0; va_ok = '0; req_port = '0;
  endtask

  task automatic put(input int i, input int v, input int port, input bit spec);
    req_vld[i*V+v]            = 1'b1;
    req_spec[i*V+v]           = spec;
    req_port[(i*V+v)*PW +: PW] = PW'(port);
  endtask

  // advance past a rising edge, then drive
  task automatic nxt();
    @(posedge clk); #1;
  endtask

  function automatic int row(input int i);
    return int'(sw_gnt[i*P +: P]);
  endfunction

  function automatic int who_got(input int o);
    int w = -1;
    for (int i = 0; i < P; i++) if (sw_gnt[i*P+o]) w = i;
    return w;
  endfunction

  function automatic int who_wasted();
    int w = -1;
    for (int i = 0; i < P; i++) if (sw_waste[i]) w = i;
    return w;
  endfunction

  task automatic invariants();
    for (int i = 0; i < P; i++) begin
      int vc;
      chk($countones(row(i)) <= 1, "R2 row one-hot", row(i), 0);
      vc = int'(sw_vc[i]);
      if (row(i) != 0) begin
        chk(req_vld[i*V+vc] == 1'b1, "R4 granted VC valid", int'(req_vld[i*V+vc]), 1);
        chk(row(i) == (1 << int'(req_port[(i*V+vc)*PW +: PW])), "R4 port match",
            row(i), 1 << int'(req_port[(i*V+vc)*PW +: PW]));
        if (req_spec[i*V+vc])
          chk(va_ok[i*V+vc] == 1'b1, "R7 spec grant needs va", int'(va_ok[i*V+vc]), 1);
      end
      if (sw_waste[i]) begin
        chk(row(i) == 0, "R7 waste row empty", row(i), 0);
        chk(req_spec[i*V+vc] && !va_ok[i*V+vc], "R7 waste cause",
            int'(va_ok[i*V+vc]), 0);
      end
    end
    for (int o = 0; o < P; o++) begin
      int c = 0;
      for (int i = 0; i < P; i++) c += int'(sw_gnt[i*P+o]);
      chk(c <= 1, "R3 column one-hot", c, 1);
    end
  endtask

  initial begin
    #(CLK_P*200000);
    if (!done) begin
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int w, w2, seen;
    clr();
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R11: idle after reset
    @(negedge clk);
    chk(sw_gnt == '0, "R11 no grant idle", int'(sw_gnt), 0);
    chk(sw_waste == '0, "R11 no waste idle", int'(sw_waste), 0);

    // R11: pointer starts at index 0; R9 then rotates
    nxt(); clr(); put(0,0,2,0); put(3,0,2,0);
    @(negedge clk);
    chk(row(0) == 5'b00100, "R11 reset priority to input 0", row(0), 4);
    chk(row(3) == 0, "R11 input 3 waits", row(3), 0);
    nxt();
    @(negedge clk);
    chk(row(3) == 5'b00100, "R9 rotation to input 3", row(3), 4);

    // R4: single request
    nxt(); clr(); put(1,1,4,0);
    @(negedge clk);
    chk(row(1) == 5'b10000, "R4 single grant port", row(1), 16);
    chk(sw_vc[1] == 1'b1, "R1 reported VC", int'(sw_vc[1]), 1);

    // R9: starvation freedom, all inputs to output 3
    nxt(); clr();
    for (int i = 0; i < P; i++) put(i,0,3,0);
    seen = 0;
    for (int c = 0; c < P; c++) begin
      @(negedge clk);
      w = who_got(3);
      chk(w >= 0, "R9 output busy each cycle", w, 0);
      if (w >= 0) begin
        chk(((seen >> w) & 1) == 0, "R9 no repeat within P cycles", w, -1);
        seen |= (1 << w);
      end
      nxt();
    end
    chk(seen == 5'b11111, "R9 every input served", seen, 31);

    // R10: VC alternation at one input
    clr(); put(2,0,0,0); put(2,1,1,0);
    @(negedge clk);
    w = int'(sw_vc[2]);
    chk(row(2) == (w == 0 ? 1 : 2), "R10 first pick port", row(2), (w == 0 ? 1 : 2));
    nxt();
    @(negedge clk);
    chk(int'(sw_vc[2]) == 1 - w, "R10 alternates VC", int'(sw_vc[2]), 1 - w);
    chk(row(2) == (w == 0 ? 2 : 1), "R10 second pick port", row(2), (w == 0 ? 2 : 1));

    // R5: non-speculative wins the shared output
    nxt(); clr(); va_ok = '1; put(0,0,1,1); put(4,1,1,0);
    @(negedge clk);
    chk(row(4) == 5'b00010, "R5 non-spec granted", row(4), 2);
    chk(row(0) == 0, "R5 spec dropped", row(0), 0);
    chk(sw_waste == '0, "R5 no waste", int'(sw_waste), 0);

    // R6: input with non-spec grant loses its spec grant
    nxt(); clr(); va_ok = '1; put(1,0,0,0); put(1,1,3,1);
    @(negedge clk);
    chk(row(1) == 5'b00001, "R6 non-spec kept", row(1), 1);
    chk(sw_vc[1] == 1'b0, "R6 VC of kept grant", int'(sw_vc[1]), 0);
    chk(who_got(3) == -1, "R6 output 3 left free", who_got(3), -1);

    // R7: waste then retry
    nxt(); clr(); put(2,1,2,1);
    @(negedge clk);
    chk(row(2) == 0, "R7 no grant on VA fail", row(2), 0);
    chk(sw_waste[2] == 1'b1, "R7 waste flag", int'(sw_waste[2]), 1);
    chk(sw_vc[2] == 1'b1, "R7 waste VC", int'(sw_vc[2]), 1);
    nxt(); va_ok[2*V+1] = 1'b1;
    @(negedge clk);
    chk(row(2) == 5'b00100, "R7 retry granted", row(2), 4);
    chk(sw_waste[2] == 1'b0, "R7 waste cleared", int'(sw_waste[2]), 0);

    // R8: wasted grants keep pointers
    nxt(); clr(); put(0,0,4,1); put(3,0,4,1);
    @(negedge clk);
    w = who_wasted();
    chk(w == 0 || w == 3, "R8 one waster", w, 0);
    nxt();
    @(negedge clk);
    chk(who_wasted() == w, "R8 same winner after waste", who_wasted(), w);
    nxt(); va_ok = '1;
    @(negedge clk);
    chk(who_got(4) == w, "R8 same winner granted", who_got(4), w);
    nxt();
    @(negedge clk);
    w2 = (w == 0) ? 3 : 0;
    chk(who_got(4) == w2, "R8 pointer moves after use", who_got(4), w2);

    // random sweep over the invariants
    for (int n = 0; n < 3000; n++) begin
      nxt(); clr();
      for (int k = 0; k < P*V; k++) begin
        if (($urandom % 4) != 0) begin
          req_vld[k]  = 1'b1;
          req_spec[k] = ($urandom % 2) == 1;
          req_port[k*PW +: PW] = PW'($urandom % P);
        end
        va_ok[k] = ($urandom % 3) != 0;
      end
      @(negedge clk);
      invariants();
    end

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule